// File: doc/BRIEF.md
# Main Supply On/Off Sequencer

This block decides whether the system's main power rail is enabled. It drives one active-low, open-drain enable pin, represented by an output-enable line plus a data line tied low. When the output enable is high, the pin is pulled low and the supply is on. When it is low, the pin floats and the supply is off.

While the supply is off, the block listens for wake requests. These are an alarm pulse from an external calendar, a falling edge on either of two modem ring-indicate lines, rising edges on a dedicated ring line, and a press of the front-panel switch. The ring line can accept a single pulse, or it can require a programmed number of pulses inside a time window.

While the supply is on, the block listens for three shutdown causes. The first is a second switch press. The second is a software shutdown command. The third is a fail-safe timeout: the system asked for power-save and then failed to acknowledge within a limit. A slow tick input paces the debounce, the ring window and the fail-safe counter. A small register port gives access to the enables, the ring threshold, the sticky wake-cause status and the shutdown command.

Top module: `pwr_onoff_ctl`

## Requirements
- R1: After reset the supply is off (`pwr_oe_o`=0), the enable register (address 0) and the status register (address 1) both read 0x00, and `pwr_pin_o` is constantly 0.
- R2: While the supply is off and enable bit 0 is set, a high level on `alarm_i` turns the supply on at the next clock edge.
- R3: While the supply is off, a falling edge on `ri_n_i[0]` with enable bit 1 set, or on `ri_n_i[1]` with enable bit 2 set, turns the supply on at that clock edge.
- R4: When enable bit 3 is set and enable bit 4 is clear (single-pulse mode), one rising edge on `ring_i` while the supply is off turns it on.
- R5: When enable bits 3 and 4 are both set (train mode), the supply turns on at the rising edge of `ring_i` that brings the pulse count to the threshold held in address 3 bits [3:0], where a threshold of 0 acts as 1. The count starts at the first rising edge. If RING_WIN ticks pass before the threshold is reached, the count restarts.
- R6: A wake source whose enable bit is clear never turns the supply on. Wake events that arrive while the supply is on change neither the power state nor the status.
- R7: `switch_n_i` is active low and debounced. A level different from the debounced one must hold for DEB_TICKS consecutive ticks before it is accepted. Shorter glitches are ignored. Each accepted press toggles the supply.
- R8: With enable bit 5 set and the supply on, holding `psave_req_i` for FS_LIMIT ticks without a `sw_ack_i` turns the supply off. An acknowledge restarts the count. With bit 5 clear, `psave_req_i` has no effect.
- R9: Writing 1 to bit 0 of address 2 turns the supply off at that clock edge. Address 2 reads 0.
- R10: The status register (address 1) has bit 0 for alarm, bits 1 and 2 for the ring-indicate lines, bit 3 for ring and bit 4 for switch. On a power-on, every cause active in that cycle sets its bit. Writing 1 to a bit clears it, but a set in the same cycle wins over the clear. Bit 7 reads the current power state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow-time enable pacing debounce, ring window and fail-safe |
| alarm_i | input | 1 | Calendar alarm, active high |
| ri_n_i | input | 2 | Modem ring-indicate lines, falling edge wakes |
| ring_i | input | 1 | Dedicated ring line, rising edges counted |
| switch_n_i | input | 1 | Power switch, low while pressed |
| psave_req_i | input | 1 | Power-save request from the system |
| sw_ack_i | input | 1 | Software alive acknowledge |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| pwr_oe_o | output | 1 | Enable pin output enable; 1 = pin pulled low = supply on |
| pwr_pin_o | output | 1 | Enable pin data, constant 0 |

## Verification
Two pairs of functions can collide in a single cycle.

The first pair is a wake event and a status clear. The bench raises the alarm in the same cycle that it writes 1 to the alarm status bit. It then expects the bit to read as set, because the set takes priority.

The second pair is several wake sources at once. Random trials drive random subsets of the alarm, ring-indicate and ring inputs together under random enable masks. For each trial, a bench function predicts the power state and the exact combination of status bits.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
   localparam logic [1:0] A_ENABLE = 2'd0;
   localparam logic [1:0] A_STATUS = 2'd1;
   localparam logic [1:0] A_CMD    = 2'd2;
   localparam logic [1:0] A_THRESH = 2'd3;

   localparam int N_RI  = 2;
   localparam int N_SRC = 5;

   // status / wake vector bit positions
   localparam int B_ALARM  = 0;
   localparam int B_RI0    = 1;
   localparam int B_RING   = 3;
   localparam int B_SWITCH = 4;

   // enable register bit positions
   localparam int E_TRAIN = 4;
   localparam int E_FSAFE = 5;
   localparam int EN_W    = 6;
endpackage

// File: rtl/pwr_sw_debounce.sv
module pwr_sw_debounce #(
   parameter int DEB_TICKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic raw_n_i,
   output logic press_o
);
   localparam int CW = $clog2(DEB_TICKS + 1);

   if (DEB_TICKS < 2) begin : g_bad_deb
      $error("DEB_TICKS must be at least 2");
   end

   logic          stable_q;
   logic [CW-1:0] cnt_q;
   logic          last_tick;

   assign last_tick = tick && (raw_n_i != stable_q) && (cnt_q == CW'(DEB_TICKS - 1));
   assign press_o   = last_tick && !raw_n_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stable_q <= 1'b1;
         cnt_q    <= '0;
      end else if (raw_n_i == stable_q) begin
         cnt_q <= '0;
      end else if (tick) begin
         if (last_tick) begin
            stable_q <= raw_n_i;
            cnt_q    <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   p_press_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      press_o |-> (!raw_n_i && !$past(raw_n_i)));
endmodule

// File: rtl/pwr_ring_detect.sv
module pwr_ring_detect #(
   parameter int RING_WIN = 64,
   parameter int CW       = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          ring_i,
   input  logic          train_i,
   input  logic [CW-1:0] thresh_i,
   output logic          fire_o
);
   localparam int WW = $clog2(RING_WIN + 1);

   if (RING_WIN < 2) begin : g_bad_win
      $error("RING_WIN must be at least 2");
   end

   logic          ring_q, active_q, rise;
   logic [CW-1:0] cnt_q;
   logic [WW-1:0] win_q;
   logic [CW:0]   need, next_cnt;

   assign rise     = ring_i && !ring_q;
   assign need     = (thresh_i == '0) ? (CW+1)'(1) : {1'b0, thresh_i};
   assign next_cnt = active_q ? ({1'b0, cnt_q} + 1'b1) : (CW+1)'(1);
   assign fire_o   = rise && (!train_i || (next_cnt >= need));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ring_q   <= 1'b0;
         active_q <= 1'b0;
         cnt_q    <= '0;
         win_q    <= '0;
      end else begin
         ring_q <= ring_i;
         if (rise) begin
            if (fire_o) begin
               active_q <= 1'b0;
               cnt_q    <= '0;
            end else begin
               active_q <= 1'b1;
               cnt_q    <= next_cnt[CW-1:0];
               if (!active_q) win_q <= '0;
            end
         end else if (active_q && tick) begin
            if (win_q == WW'(RING_WIN - 1)) begin
               active_q <= 1'b0;
               cnt_q    <= '0;
            end else begin
               win_q <= win_q + 1'b1;
            end
         end
      end
   end

   p_fire_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |-> (ring_i && !$past(ring_i)));
   p_window_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (win_q < WW'(RING_WIN)));
endmodule

// File: rtl/pwr_failsafe.sv
module pwr_failsafe #(
   parameter int FS_LIMIT = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic arm_i,
   input  logic ack_i,
   output logic trip_o
);
   localparam int CW = $clog2(FS_LIMIT + 1);

   if (FS_LIMIT < 2) begin : g_bad_fs
      $error("FS_LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign trip_o = arm_i && !ack_i && tick && (cnt_q == CW'(FS_LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!arm_i || ack_i) cnt_q <= '0;
      else if (tick)            cnt_q <= trip_o ? '0 : cnt_q + 1'b1;
   end

   p_trip_after_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      trip_o |-> ($past(arm_i) && !$past(ack_i)));
endmodule

// File: rtl/pwr_onoff_ctl.sv
module pwr_onoff_ctl
   import pwr_pkg::*;
#(
   parameter int DEB_TICKS = 16,
   parameter int FS_LIMIT  = 1024,
   parameter int RING_WIN  = 64,
   parameter int RING_CW   = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       alarm_i,
   input  logic [1:0] ri_n_i,
   input  logic       ring_i,
   input  logic       switch_n_i,
   input  logic       psave_req_i,
   input  logic       sw_ack_i,
   input  logic       reg_wr_i,
   input  logic [1:0] reg_addr_i,
   input  logic [7:0] reg_wdata_i,
   output logic [7:0] reg_rdata_o,
   output logic       pwr_oe_o,
   output logic       pwr_pin_o
);
   if (RING_CW > 8 || RING_CW < 1) begin : g_bad_cw
      $error("RING_CW must be 1..8");
   end

   logic [EN_W-1:0]    en_q;
   logic [N_SRC-1:0]   stat_q, wake_vec, clr_vec;
   logic [RING_CW-1:0] thr_q;
   logic [N_RI-1:0]    ri_q, ri_fall;
   logic               pwr_q, press, ring_fire, fs_trip, sw_off, wake_any;

   for (genvar i = 0; i < N_RI; i++) begin : g_ri
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ri_q[i] <= 1'b1;
         else        ri_q[i] <= ri_n_i[i];
      end
      assign ri_fall[i]          = ri_q[i] && !ri_n_i[i];
      assign wake_vec[B_RI0 + i] = ri_fall[i] && en_q[B_RI0 + i];
   end

   pwr_sw_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
      .clk(clk), .rst_n(rst_n), .tick(tick), .raw_n_i(switch_n_i), .press_o(press));

   pwr_ring_detect #(.RING_WIN(RING_WIN), .CW(RING_CW)) u_ring (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ring_i(ring_i),
      .train_i(en_q[E_TRAIN]), .thresh_i(thr_q), .fire_o(ring_fire));

   pwr_failsafe #(.FS_LIMIT(FS_LIMIT)) u_fs (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .arm_i(pwr_q && en_q[E_FSAFE] && psave_req_i), .ack_i(sw_ack_i), .trip_o(fs_trip));

   assign wake_vec[B_ALARM]  = alarm_i && en_q[B_ALARM];
   assign wake_vec[B_RING]   = ring_fire && en_q[B_RING];
   assign wake_vec[B_SWITCH] = press;
   assign wake_any = !pwr_q && (|wake_vec);
   assign sw_off   = reg_wr_i && (reg_addr_i == A_CMD) && reg_wdata_i[0];
   assign clr_vec  = (reg_wr_i && reg_addr_i == A_STATUS) ? reg_wdata_i[N_SRC-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_q  <= 1'b0;
         en_q   <= '0;
         stat_q <= '0;
         thr_q  <= '0;
      end else begin
         if (wake_any)                               pwr_q <= 1'b1;
         else if (pwr_q && (press || fs_trip || sw_off)) pwr_q <= 1'b0;
         stat_q <= (stat_q & ~clr_vec) | (wake_any ? wake_vec : '0);
         if (reg_wr_i && reg_addr_i == A_ENABLE) en_q  <= reg_wdata_i[EN_W-1:0];
         if (reg_wr_i && reg_addr_i == A_THRESH) thr_q <= reg_wdata_i[RING_CW-1:0];
      end
   end

   always_comb begin
      unique case (reg_addr_i)
         A_ENABLE: reg_rdata_o = 8'(en_q);
         A_STATUS: reg_rdata_o = {pwr_q, 2'b00, stat_q};
         A_THRESH: reg_rdata_o = 8'(thr_q);
         default:  reg_rdata_o = 8'h00;
      endcase
   end

   assign pwr_oe_o  = pwr_q;
   assign pwr_pin_o = 1'b0;

   p_wake_turns_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_oe_o && (|wake_vec)) |=> pwr_oe_o);
   p_sw_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_oe_o && sw_off) |=> !pwr_oe_o);
   p_status_hold_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_oe_o && !(reg_wr_i && reg_addr_i == A_STATUS)) |=> $stable(stat_q));
   p_status_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_wr_i && reg_addr_i == A_STATUS) && !wake_any)
      |=> ((stat_q & $past(reg_wdata_i[N_SRC-1:0])) == '0));
endmodule

// File: tb/tb_pwr_onoff_ctl.sv
`timescale 1ns/1ps
module tb_pwr_onoff_ctl;
   localparam int DEB = 4, FSL = 8, WIN = 16;

   logic clk = 0, rst_n = 0, tick = 1, alarm = 0, ring = 0, sw_n = 1;
   logic psave = 0, ack = 0, wr = 0;
   logic [1:0] ri_n = 2'b11, addr = 0;
   logic [7:0] wdata = 0, rdata;
   logic pwr_oe, pwr_pin;
   int checks = 0, errors = 0;
   bit done = 0;

   pwr_onoff_ctl #(.DEB_TICKS(DEB), .FS_LIMIT(FSL), .RING_WIN(WIN), .RING_CW(4)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .alarm_i(alarm), .ri_n_i(ri_n),
      .ring_i(ring), .switch_n_i(sw_n), .psave_req_i(psave), .sw_ack_i(ack),
      .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .pwr_oe_o(pwr_oe), .pwr_pin_o(pwr_pin));

   always #10 clk = ~clk;

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wreg(input logic [1:0] a, input logic [7:0] d);
      wr = 1; addr = a; wdata = d;
      @(negedge clk);
      wr = 0; addr = 0;
   endtask

   task automatic rreg(input logic [1:0] a, output logic [7:0] d);
      addr = a; #1; d = rdata; addr = 0;
   endtask

   task automatic reset_off();
      wreg(2'd2, 8'h01);
      wreg(2'd1, 8'h1F);
   endtask

   task automatic ring_pulse();
      ring = 1; @(negedge clk); ring = 0; @(negedge clk);
   endtask

   function automatic logic [7:0] exp_status(input logic [3:0] en, input logic [3:0] src);
      logic [3:0] hit = en & src;
      return {(|hit), 3'b000, hit};
   endfunction

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int seed;
      seed = $urandom(32'd1234);
      cyc(3); rst_n = 1; cyc(1);
      // R1 reset state
      check(pwr_oe, 0, "R1 oe"); check(pwr_pin, 0, "R1 pin");
      rreg(2'd0, d); check(d, 8'h00, "R1 enable");
      rreg(2'd1, d); check(d, 8'h00, "R1 status");

      // R2 alarm wake
      wreg(2'd0, 8'h01);
      alarm = 1; @(negedge clk); alarm = 0;
      check(pwr_oe, 1, "R2 alarm on");
      rreg(2'd1, d); check(d, 8'h81, "R10 alarm status");
      // R6 events while on are ignored
      alarm = 1; @(negedge clk); alarm = 0; cyc(1);
      rreg(2'd1, d); check(d, 8'h81, "R6 ignored while on");
      wreg(2'd1, 8'h01);
      rreg(2'd1, d); check(d, 8'h80, "R10 w1c");
      // R9 software off
      wreg(2'd2, 8'h01);
      check(pwr_oe, 0, "R9 sw off");
      rreg(2'd2, d); check(d, 8'h00, "R9 cmd reads 0");

      // R6 disabled sources
      wreg(2'd0, 8'h00);
      alarm = 1; ri_n = 2'b00; ring = 1; @(negedge clk);
      alarm = 0; ri_n = 2'b11; ring = 0; cyc(2);
      check(pwr_oe, 0, "R6 disabled off");
      rreg(2'd1, d); check(d, 8'h00, "R6 disabled status");

      // R3 ring indicate lines
      wreg(2'd0, 8'h02);
      ri_n[0] = 0; @(negedge clk); ri_n[0] = 1;
      check(pwr_oe, 1, "R3 ri0 on");
      rreg(2'd1, d); check(d, 8'h82, "R3 ri0 status");
      reset_off();
      wreg(2'd0, 8'h04);
      ri_n[1] = 0; @(negedge clk); ri_n[1] = 1;
      check(pwr_oe, 1, "R3 ri1 on");
      rreg(2'd1, d); check(d, 8'h84, "R3 ri1 status");
      reset_off();

      // R4 single ring pulse
      wreg(2'd0, 8'h08);
      ring = 1; @(negedge clk); ring = 0;
      check(pwr_oe, 1, "R4 ring single");
      rreg(2'd1, d); check(d, 8'h88, "R4 ring status");
      reset_off();

      // R5 pulse train with window expiry
      wreg(2'd3, 8'h03);
      wreg(2'd0, 8'h18);
      ring_pulse(); ring_pulse();
      check(pwr_oe, 0, "R5 two pulses short");
      cyc(WIN + 4);
      ring_pulse(); ring_pulse();
      check(pwr_oe, 0, "R5 window restarted");
      ring = 1; @(negedge clk); ring = 0;
      check(pwr_oe, 1, "R5 threshold reached");
      reset_off();
      wreg(2'd3, 8'h00);
      ring = 1; @(negedge clk); ring = 0;
      check(pwr_oe, 1, "R5 threshold zero acts as one");
      reset_off();

      // R7 switch debounce
      wreg(2'd0, 8'h00);
      sw_n = 0; cyc(DEB - 2); sw_n = 1; cyc(DEB + 2);
      check(pwr_oe, 0, "R7 glitch ignored");
      sw_n = 0; cyc(DEB + 2);
      check(pwr_oe, 1, "R7 press on");
      rreg(2'd1, d); check(d, 8'h90, "R7 switch status");
      sw_n = 1; cyc(DEB + 2);
      check(pwr_oe, 1, "R7 release no toggle");
      sw_n = 0; cyc(DEB + 2); sw_n = 1; cyc(DEB + 2);
      check(pwr_oe, 0, "R7 second press off");
      wreg(2'd1, 8'h1F);

      // R8 fail-safe
      wreg(2'd0, 8'h21);
      alarm = 1; @(negedge clk); alarm = 0;
      psave = 1; cyc(4);
      ack = 1; @(negedge clk); ack = 0;
      cyc(FSL - 2);
      check(pwr_oe, 1, "R8 ack restarts count");
      cyc(4);
      check(pwr_oe, 0, "R8 timeout off");
      psave = 0; reset_off();
      wreg(2'd0, 8'h01);
      alarm = 1; @(negedge clk); alarm = 0;
      psave = 1; cyc(3 * FSL); psave = 0;
      check(pwr_oe, 1, "R8 disabled fail-safe");
      reset_off();

      // R10 set and clear in the same cycle
      wreg(2'd0, 8'h01);
      alarm = 1; wr = 1; addr = 2'd1; wdata = 8'h01;
      @(negedge clk);
      alarm = 0; wr = 0; addr = 0;
      rreg(2'd1, d); check(d, 8'h81, "R10 set wins over clear");
      reset_off();

      // random simultaneous wake sources (R2 R3 R4 R6 R10)
      for (int it = 0; it < 24; it++) begin
         logic [3:0] en, src;
         en = 4'($urandom); src = 4'($urandom);
         reset_off();
         wreg(2'd0, {4'b0000, en});
         alarm = src[0]; ri_n = ~src[2:1]; ring = src[3];
         @(negedge clk);
         alarm = 0; ri_n = 2'b11; ring = 0;
         check(pwr_oe, |(en & src), "R6 random power state");
         rreg(2'd1, d); check(d, exp_status(en, src), "R10 random status");
         cyc(1);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule